// File: doc/BRIEF.md
# Coarse Vertical Timing Generator

This block produces the vertical blanking and vertical sync levels for a display raster without a line counter or comparators. It is fed by a horizontal unit strobe (one pulse per 0.99 us time unit) and a line-start strobe (one pulse per scanline). Two one-hot rings of coprime lengths, 16 and 33, step on the horizontal unit strobe. The cycle in which both rings sit on their last position marks a vertical unit boundary. That happens once every 528 horizontal units, or 522.72 us.

A 32-position circulating bit pattern steps once per vertical unit, so a frame lasts 32 vertical units, about 16.73 ms or roughly 59.78 Hz. The pattern holds one contiguous run of three set bits: one unit of front porch followed by two units of back porch. Blanking is driven from this run, and the remaining 29 units are active lines.

When the pattern leaves its first blank unit, a sync shaper turns vertical sync on. The shaper then counts line-start strobes and turns sync off on the second one, so the pulse lasts two scanlines. Reset puts the frame at the start of blanking. Both outputs come straight from flip-flops, and the active level of sync is a parameter.

Top module: `vfp_vtiming`

## Requirements
- R1: A vertical unit boundary occurs on every 528th clock in which `h_tick` is high (528 = 16 x 33), counted from reset. Clocks with `h_tick` low do not count.
- R2: While `rst` is high and after it is released, `vblank` is 1 and `vsync` is at its inactive level. The first boundary after reset then comes after exactly 528 `h_tick` strobes, whatever state the block was in before reset.
- R3: Number the vertical units of a frame 0 to 31, with unit 0 starting at reset. `vblank` is 1 during units 0, 1 and 2, is 0 during units 3 to 31, and the pattern repeats every 32 units.
- R4: `vblank` changes only at the clock edge that samples a vertical unit boundary. Idle cycles and non-boundary `h_tick` cycles leave it unchanged.
- R5: `vsync` goes to its active level at the edge that samples the boundary from unit 0 to unit 1, in every frame.
- R6: `vsync` returns to its inactive level at the edge that samples the second `line_start` strobe after activation. A `line_start` in the same cycle as activation is not counted.
- R7: `line_start` strobes while `vsync` is inactive have no effect. `vsync` stays inactive, and the next pulse still lasts two line starts.
- R8: The active level of `vsync` equals parameter `SYNC_POL` (default 1, active high), and both outputs are driven directly by registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| h_tick | input | 1 | Horizontal unit strobe, one clock wide per 0.99 us unit |
| line_start | input | 1 | Scanline start strobe |
| vblank | output | 1 | Vertical blanking, high during the three porch units |
| vsync | output | 1 | Vertical sync, two scanlines long, active level `SYNC_POL` |

## Verification
The assertion that sync sits inside blanking assumes that at least two `line_start` strobes arrive within the two back-porch units, about 1056 horizontal units. In a real raster that window holds some 33 lines. The sync-shaper properties also assume that `line_start` does not fall on a vertical unit boundary cycle. The stimulus meets both conditions. It raises `line_start` only in cycles where `h_tick` is low, and it always delivers the two closing line starts within unit 1. The bench also inserts idle gaps inside tick runs, so that the 528-count is checked against strobes and not against raw clocks.

// File: rtl/vfp_pkg.sv
package vfp_pkg;

  // Greatest common divisor, used at elaboration to require coprime rings.
  function automatic int gcd(input int a, input int b);
    int x;
    int y;
    int t;
    x = a;
    y = b;
    while (y != 0) begin
      t = x % y;
      x = y;
      y = t;
    end
    return x;
  endfunction

endpackage

// File: rtl/vfp_onehot_ring.sv
module vfp_onehot_ring #(
  parameter int LEN = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic adv,
  output logic at_last
);
  logic [LEN-1:0] pos;

  always_ff @(posedge clk) begin
    if (rst) pos <= {{(LEN-1){1'b0}}, 1'b1};
    else if (adv) pos <= {pos[LEN-2:0], pos[LEN-1]};
  end

  assign at_last = pos[LEN-1];

  // R1: exactly one position is marked in each ring
  assert_ring_onehot_R1: assert property (@(posedge clk) disable iff (rst)
    $countones(pos) == 1);

endmodule

// File: rtl/vfp_phase_div.sv
module vfp_phase_div #(
  parameter int A = 16,
  parameter int B = 33
) (
  input  logic clk,
  input  logic rst,
  input  logic h_tick,
  output logic v_tick
);
  localparam int PERIOD = A * B;
  localparam int CW     = $clog2(PERIOD);

  logic a_last, b_last;

  vfp_onehot_ring #(.LEN(A)) u_ring_a (
    .clk(clk), .rst(rst), .adv(h_tick), .at_last(a_last)
  );
  vfp_onehot_ring #(.LEN(B)) u_ring_b (
    .clk(clk), .rst(rst), .adv(h_tick), .at_last(b_last)
  );

  assign v_tick = h_tick & a_last & b_last;

  initial assert (vfp_pkg::gcd(A, B) == 1);

  // Independent strobe counter used only by the check below.
  logic [CW-1:0] seen;
  always_ff @(posedge clk) begin
    if (rst) seen <= '0;
    else if (h_tick) seen <= v_tick ? '0 : seen + 1'b1;
  end

  // R1: boundary coincides with the PERIOD-th strobe and no other
  assert_vtick_period_R1: assert property (@(posedge clk) disable iff (rst)
    h_tick |-> (v_tick == (seen == CW'(PERIOD - 1))));

endmodule

// File: rtl/vfp_blank_ring.sv
module vfp_blank_ring #(
  parameter int LEN = 32,
  parameter int RUN = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic adv,
  output logic blank,
  output logic first_unit
);
  function automatic logic [LEN-1:0] init_pattern();
    logic [LEN-1:0] p;
    for (int i = 0; i < LEN; i++) p[i] = (i < RUN);
    return p;
  endfunction

  localparam logic [LEN-1:0] INIT = init_pattern();

  logic [LEN-1:0] ring;

  always_ff @(posedge clk) begin
    if (rst) ring <= INIT;
    else if (adv) ring <= {ring[0], ring[LEN-1:1]};
  end

  assign blank      = ring[0];
  assign first_unit = ring[0] & ~ring[LEN-1];

  // R3: the run of blank units keeps its length while circulating
  assert_run_length_R3: assert property (@(posedge clk) disable iff (rst)
    $countones(ring) == RUN);

  // R4: the pattern moves only on a vertical unit boundary
  assert_hold_between_R4: assert property (@(posedge clk) disable iff (rst)
    !adv |=> $stable(ring));

endmodule

// File: rtl/vfp_sync_shaper.sv
module vfp_sync_shaper #(
  parameter int LINES = 2,
  parameter bit POL   = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic line_start,
  output logic sync_q
);
  localparam int CW = $clog2(LINES + 1);

  logic          active, nxt_active;
  logic [CW-1:0] cnt, nxt_cnt;

  always_comb begin
    nxt_active = active;
    nxt_cnt    = cnt;
    if (start) begin
      nxt_active = 1'b1;
      nxt_cnt    = '0;
    end else if (active && line_start) begin
      if (cnt == CW'(LINES - 1)) begin
        nxt_active = 1'b0;
        nxt_cnt    = '0;
      end else begin
        nxt_cnt = cnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      cnt    <= '0;
      sync_q <= ~POL;
    end else begin
      active <= nxt_active;
      cnt    <= nxt_cnt;
      sync_q <= nxt_active ? POL : ~POL;
    end
  end

  // R5: a trigger always opens the pulse
  assert_open_R5: assert property (@(posedge clk) disable iff (rst)
    start |=> active);

  // R6: the pulse only closes on a line start
  assert_close_on_line_R6: assert property (@(posedge clk) disable iff (rst)
    (active && !start && !line_start) |=> active);

  // R6: line count stays below the pulse width
  assert_count_range_R6: assert property (@(posedge clk) disable iff (rst)
    active |-> (cnt < CW'(LINES)));

  // R7: line starts cannot open a pulse
  assert_idle_stays_R7: assert property (@(posedge clk) disable iff (rst)
    (!active && !start) |=> !active);

endmodule

// File: rtl/vfp_vtiming.sv
module vfp_vtiming #(
  parameter int DIV_A       = 16,
  parameter int DIV_B       = 33,
  parameter int UNITS       = 32,
  parameter int BLANK_UNITS = 3,
  parameter int SYNC_LINES  = 2,
  parameter bit SYNC_POL    = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic h_tick,
  input  logic line_start,
  output logic vblank,
  output logic vsync
);
  logic v_tick;
  logic first_unit;
  logic sync_start;

  vfp_phase_div #(.A(DIV_A), .B(DIV_B)) u_div (
    .clk(clk), .rst(rst), .h_tick(h_tick), .v_tick(v_tick)
  );

  vfp_blank_ring #(.LEN(UNITS), .RUN(BLANK_UNITS)) u_blank (
    .clk(clk), .rst(rst), .adv(v_tick),
    .blank(vblank), .first_unit(first_unit)
  );

  // Leaving the first blank unit (front porch) triggers sync.
  assign sync_start = v_tick & first_unit;

  vfp_sync_shaper #(.LINES(SYNC_LINES), .POL(SYNC_POL)) u_sync (
    .clk(clk), .rst(rst), .start(sync_start),
    .line_start(line_start), .sync_q(vsync)
  );

  // R3: sync lies inside blanking (needs line starts within the back porch)
  assert_sync_in_blank_R3: assert property (@(posedge clk) disable iff (rst)
    (vsync == SYNC_POL) |-> vblank);

endmodule

// File: tb/vfp_vtiming_test.sv
module vfp_vtiming_test;
  localparam int CLK_PERIOD = 10;
  localparam int UNIT = 528;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic h_tick = 1'b0;
  logic line_start = 1'b0;
  logic vblank, vsync;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vfp_vtiming uut (
    .clk(clk), .rst(rst), .h_tick(h_tick), .line_start(line_start),
    .vblank(vblank), .vsync(vsync)
  );

  task automatic chk(input logic got, input logic exp, input string req, input string what);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: got %b expected %b", req, what, got, exp);
    end
  endtask

  // Hold h_tick high for n clock edges, then lower it; returns at a falling edge.
  task automatic ticks(input int n);
    if (n > 0) begin
      @(negedge clk) h_tick = 1'b1;
      repeat (n) @(negedge clk);
      h_tick = 1'b0;
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic line();
    @(negedge clk) line_start = 1'b1;
    @(negedge clk) line_start = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk) rst = 1'b1;
    idle(3);
    chk(vblank, 1'b1, "R2", "vblank during reset");
    chk(vsync, 1'b0, "R2", "vsync during reset");
    rst = 1'b0;
    idle(1);
  endtask

  task automatic t_reset_state();
    do_reset();
    chk(vblank, 1'b1, "R2", "vblank after reset");
    chk(vsync, 1'b0, "R2", "vsync after reset");
  endtask

  task automatic t_first_boundary();
    ticks(300);
    idle(7);
    ticks(227);
    chk(vsync, 1'b0, "R1", "no boundary after 527 strobes");
    chk(vblank, 1'b1, "R4", "vblank held before boundary");
    ticks(1);
    chk(vsync, 1'b1, "R5", "sync opens entering unit 1");
    chk(vsync, 1'b1, "R8", "active level is high");
    chk(vblank, 1'b1, "R3", "unit 1 blank");
  endtask

  task automatic t_sync_width();
    line();
    chk(vsync, 1'b1, "R6", "sync held after first line");
    line();
    chk(vsync, 1'b0, "R6", "sync closed after second line");
    line();
    chk(vsync, 1'b0, "R7", "stray line while idle");
  endtask

  task automatic t_blank_pattern();
    ticks(UNIT);
    chk(vblank, 1'b1, "R3", "unit 2 blank");
    ticks(UNIT);
    chk(vblank, 1'b0, "R3", "unit 3 active");
    ticks(UNIT - 1);
    idle(20);
    chk(vblank, 1'b0, "R4", "no change before unit 4 boundary");
    ticks(1);
    ticks(27 * UNIT);
    chk(vblank, 1'b0, "R3", "unit 31 active");
    chk(vsync, 1'b0, "R7", "sync idle through active region");
    ticks(UNIT);
    chk(vblank, 1'b1, "R3", "frame wraps to unit 0");
    chk(vsync, 1'b0, "R5", "no sync in unit 0");
  endtask

  task automatic t_second_frame_sync();
    line();
    line();
    line();
    chk(vsync, 1'b0, "R7", "lines in unit 0 ignored");
    ticks(UNIT);
    chk(vsync, 1'b1, "R5", "second frame sync opens");
    line();
    chk(vsync, 1'b1, "R7", "width not shortened by earlier lines");
  endtask

  task automatic t_reset_midway();
    do_reset();
    chk(vsync, 1'b0, "R2", "reset closes active sync");
    ticks(UNIT - 1);
    chk(vsync, 1'b0, "R2", "realigned: no boundary at 527");
    ticks(1);
    chk(vsync, 1'b1, "R2", "realigned boundary at 528");
    line();
    line();
    chk(vsync, 1'b0, "R6", "realigned pulse width");
    ticks(2 * UNIT);
    chk(vblank, 1'b0, "R3", "realigned unit 3 active");
    do_reset();
    chk(vblank, 1'b1, "R2", "reset restores blanking");
  endtask

  initial begin
    idle(2);
    t_reset_state();
    t_first_boundary();
    t_sync_width();
    t_blank_pattern();
    t_second_frame_sync();
    t_reset_midway();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule